// File: doc/BRIEF.md
# Dual Threshold Alarm Monitor

The block holds two alarm channels. Each channel watches one of four sample streams: a 12-bit unsigned supply reading, a 14-bit signed rate value, a 12-bit unsigned auxiliary reading or a 12-bit signed temperature. On every sample strobe a channel compares a value against its own threshold, using a strict greater-than or less-than test. In level mode the value is the current sample. In change mode it is the current sample minus the sample taken a programmed number of strobes earlier. One shared control bit chooses whether the channels see the filtered or the unfiltered copy of the streams.

A channel that trips sets a sticky status flag, which clears on a read pulse. The two channels also feed one indicator. That indicator can be enabled, given either polarity and placed on either of two digital lines. On each line a data-ready pass-through outranks the indicator, and the indicator outranks a general-purpose value.

Top module: `alm_dual_monitor`

## Requirements
- R1: A channel source code of 3'b001 selects supply, 3'b010 rate, 3'b101 auxiliary and 3'b110 temperature. Code 3'b000 and every other code disable the channel, so it never trips.
- R2: Rate (14-bit) and temperature (12-bit) are treated as two's complement. Supply and auxiliary are zero-extended. The 14-bit threshold field is read with the signedness and width of the selected source, so for 12-bit sources only its bits 11:0 count.
- R3: The sense bit set to 1 trips when the compared value is strictly greater than the threshold. Set to 0, it trips when the value is strictly less. Equality never trips.
- R4: With the mode bit set to 1, the compared value is the current sample minus the sample N strobes earlier, where N is the 8-bit window value and both 0 and 1 mean one strobe. With the mode bit at 0, the compared value is the current sample.
- R5: In change mode a channel does not trip until N samples have been recorded. The recorded history is discarded whenever the channel's source code or mode bit changes.
- R6: With use_filt at 1 both channels compare the filtered inputs. At 0 they compare the raw inputs.
- R7: stat_o[0] (channel 1) and stat_o[1] (channel 2) are set at a strobe on which the channel trips, and they hold until a stat_rd pulse clears them. A trip on the same edge as a read leaves the bit set.
- R8: The indicator level is the OR of both channels' trips at the latest strobe and holds between strobes. When enabled it appears on line_o[alm_line], inverted when alm_pol is 0.
- R9: On each line, a data-ready enabled for that line passes rdy_in. Otherwise an enabled indicator routed to that line drives it. Otherwise the line carries gp_val for that line.
- R10: After reset both status flags are 0 and the indicator level is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | One-cycle strobe marking a new sample |
| use_filt | input | 1 | 1 = compare filtered inputs, 0 = raw |
| raw_sup | input | 12 | Raw supply sample, unsigned |
| raw_rate | input | 14 | Raw rate sample, signed |
| raw_aux | input | 12 | Raw auxiliary sample, unsigned |
| raw_temp | input | 12 | Raw temperature sample, signed |
| flt_sup | input | 12 | Filtered supply sample |
| flt_rate | input | 14 | Filtered rate sample |
| flt_aux | input | 12 | Filtered auxiliary sample |
| flt_temp | input | 12 | Filtered temperature sample |
| c1_src | input | 3 | Channel 1 source code |
| c1_roc | input | 1 | Channel 1 mode: 1 = change, 0 = level |
| c1_win | input | 8 | Channel 1 change window N |
| c1_gt | input | 1 | Channel 1 sense: 1 = greater, 0 = less |
| c1_lim | input | 14 | Channel 1 threshold field |
| c2_src | input | 3 | Channel 2 source code |
| c2_roc | input | 1 | Channel 2 mode |
| c2_win | input | 8 | Channel 2 change window N |
| c2_gt | input | 1 | Channel 2 sense |
| c2_lim | input | 14 | Channel 2 threshold field |
| alm_en | input | 1 | Indicator enable |
| alm_pol | input | 1 | Indicator polarity, 1 = active high |
| alm_line | input | 1 | Indicator line, 1 = line 1, 0 = line 0 |
| rdy_en | input | 1 | Data-ready pass-through enable |
| rdy_line | input | 1 | Data-ready line select |
| rdy_in | input | 1 | Data-ready level to pass through |
| gp_val | input | 2 | General-purpose level per line |
| stat_rd | input | 1 | Status read pulse, clears the flags |
| stat_o | output | 2 | Sticky trip flags, bit 0 = channel 1 |
| line_o | output | 2 | Digital line levels |

## Verification
Status flags and the indicator level are registered at the clock edge that samples smp_stb. They are therefore due one edge after the strobe is presented. The bench drives every strobe on a falling edge and checks on the next falling edge, after exactly one rising edge. Line outputs are combinational from that registered level and from the routing inputs, so they are checked in the same window. Changes to source or mode take one edge to discard the history, and the bench always leaves one clear edge before the next strobe. Read pulses given without a strobe are checked one edge later for cleared flags and an unchanged indicator.

// File: rtl/alm_pkg.sv
package alm_pkg;

    typedef enum logic [2:0] {
        SRC_OFF    = 3'b000,
        SRC_SUPPLY = 3'b001,
        SRC_RATE   = 3'b010,
        SRC_AUX    = 3'b101,
        SRC_TEMP   = 3'b110
    } src_e;

    typedef logic signed [15:0] val_t;

    typedef struct packed {
        logic [2:0]  src;
        logic        roc;
        logic [7:0]  win;
        logic        gt;
        logic [13:0] lim;
    } ch_cfg_t;

    function automatic logic src_live(input logic [2:0] s);
        return (s == SRC_SUPPLY) || (s == SRC_RATE) ||
               (s == SRC_AUX)    || (s == SRC_TEMP);
    endfunction

    // Bring a source-format field to the common signed compare width
    function automatic val_t widen(input logic [2:0] s, input logic [13:0] f);
        case (s)
            SRC_SUPPLY, SRC_AUX: return val_t'({4'b0000, f[11:0]});
            SRC_RATE:            return val_t'({{2{f[13]}}, f});
            SRC_TEMP:            return val_t'({{4{f[11]}}, f[11:0]});
            default:             return '0;
        endcase
    endfunction

    function automatic logic beyond(input logic gt, input val_t v, input val_t t);
        return gt ? (v > t) : (v < t);
    endfunction

endpackage

// File: rtl/alm_src_mux.sv
module alm_src_mux
    import alm_pkg::*;
(
    input  logic        use_filt,
    input  logic [11:0] raw_sup,
    input  logic [13:0] raw_rate,
    input  logic [11:0] raw_aux,
    input  logic [11:0] raw_temp,
    input  logic [11:0] flt_sup,
    input  logic [13:0] flt_rate,
    input  logic [11:0] flt_aux,
    input  logic [11:0] flt_temp,
    input  logic [2:0]  sel,
    output val_t        cur
);
    logic [11:0] sup, aux, tmp;
    logic [13:0] rte;
    logic [13:0] field;

    always_comb begin
        sup = use_filt ? flt_sup  : raw_sup;
        rte = use_filt ? flt_rate : raw_rate;
        aux = use_filt ? flt_aux  : raw_aux;
        tmp = use_filt ? flt_temp : raw_temp;
        case (sel)
            SRC_SUPPLY: field = {2'b00, sup};
            SRC_RATE:   field = rte;
            SRC_AUX:    field = {2'b00, aux};
            SRC_TEMP:   field = {2'b00, tmp};
            default:    field = '0;
        endcase
        cur = widen(sel, field);
    end
endmodule

// File: rtl/alm_channel.sv
module alm_channel
    import alm_pkg::*;
#(
    parameter int HIST_DEPTH = 256
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    stb,
    input  ch_cfg_t cfg,
    input  val_t    cur,
    output logic    hit
);
    localparam int PTR_W  = $clog2(HIST_DEPTH);
    localparam int FILL_W = PTR_W + 1;

    val_t              hist [HIST_DEPTH];
    logic [PTR_W-1:0]  wp;
    logic [FILL_W-1:0] fill;
    logic [2:0]        src_q;
    logic              roc_q;

    logic              changed;
    logic [FILL_W-1:0] span;
    logic              primed;
    val_t              past, delta, thr;

    always_comb begin
        changed = (cfg.src != src_q) || (cfg.roc != roc_q);
        span    = (cfg.win == 8'd0) ? FILL_W'(1) : FILL_W'(cfg.win);
        primed  = fill >= span;
        past    = hist[wp - span[PTR_W-1:0]];
        delta   = cur - past;
        thr     = widen(cfg.src, cfg.lim);
        if (!src_live(cfg.src) || changed)
            hit = 1'b0;
        else if (cfg.roc)
            hit = primed && beyond(cfg.gt, delta, thr);
        else
            hit = beyond(cfg.gt, cur, thr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            fill  <= '0;
            src_q <= SRC_OFF;
            roc_q <= 1'b0;
        end else begin
            src_q <= cfg.src;
            roc_q <= cfg.roc;
            if (changed) begin
                fill <= '0;
            end else if (stb) begin
                wp <= wp + 1'b1;
                if (fill != FILL_W'(HIST_DEPTH))
                    fill <= fill + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && !changed && stb)
            hist[wp] <= cur;
    end

    // R5
    hist_flush_chk: assert property (@(posedge clk) disable iff (rst)
        changed |=> (fill == '0));

    // R5
    roc_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg.roc && fill == '0) |-> !hit);

endmodule

// File: rtl/alm_line_mux.sv
module alm_line_mux #(
    parameter int LINES = 2
) (
    input  logic                     rdy_en,
    input  logic [$clog2(LINES)-1:0] rdy_line,
    input  logic                     rdy_in,
    input  logic                     alm_en,
    input  logic [$clog2(LINES)-1:0] alm_line,
    input  logic                     alm_lvl,
    input  logic [LINES-1:0]         gp_val,
    output logic [LINES-1:0]         line_o
);
    localparam int SEL_W = $clog2(LINES);

    for (genvar i = 0; i < LINES; i++) begin : g_line
        always_comb begin
            if (rdy_en && rdy_line == SEL_W'(i))
                line_o[i] = rdy_in;
            else if (alm_en && alm_line == SEL_W'(i))
                line_o[i] = alm_lvl;
            else
                line_o[i] = gp_val[i];
        end
    end
endmodule

// File: rtl/alm_dual_monitor.sv
module alm_dual_monitor
    import alm_pkg::*;
#(
    parameter int HIST_DEPTH = 256
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        smp_stb,
    input  logic        use_filt,
    input  logic [11:0] raw_sup,
    input  logic [13:0] raw_rate,
    input  logic [11:0] raw_aux,
    input  logic [11:0] raw_temp,
    input  logic [11:0] flt_sup,
    input  logic [13:0] flt_rate,
    input  logic [11:0] flt_aux,
    input  logic [11:0] flt_temp,
    input  logic [2:0]  c1_src,
    input  logic        c1_roc,
    input  logic [7:0]  c1_win,
    input  logic        c1_gt,
    input  logic [13:0] c1_lim,
    input  logic [2:0]  c2_src,
    input  logic        c2_roc,
    input  logic [7:0]  c2_win,
    input  logic        c2_gt,
    input  logic [13:0] c2_lim,
    input  logic        alm_en,
    input  logic        alm_pol,
    input  logic        alm_line,
    input  logic        rdy_en,
    input  logic        rdy_line,
    input  logic        rdy_in,
    input  logic [1:0]  gp_val,
    input  logic        stat_rd,
    output logic [1:0]  stat_o,
    output logic [1:0]  line_o
);
    localparam int NCH = 2;

    ch_cfg_t          cfg [NCH];
    logic [NCH-1:0]   hit;
    logic [NCH-1:0]   stat_q;
    logic             alm_q;
    logic             alm_lvl;

    always_comb begin
        cfg[0] = '{src: c1_src, roc: c1_roc, win: c1_win, gt: c1_gt, lim: c1_lim};
        cfg[1] = '{src: c2_src, roc: c2_roc, win: c2_win, gt: c2_gt, lim: c2_lim};
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        val_t cur;

        alm_src_mux u_mux (
            .use_filt (use_filt),
            .raw_sup  (raw_sup),
            .raw_rate (raw_rate),
            .raw_aux  (raw_aux),
            .raw_temp (raw_temp),
            .flt_sup  (flt_sup),
            .flt_rate (flt_rate),
            .flt_aux  (flt_aux),
            .flt_temp (flt_temp),
            .sel      (cfg[c].src),
            .cur      (cur)
        );

        alm_channel #(.HIST_DEPTH(HIST_DEPTH)) u_ch (
            .clk (clk),
            .rst (rst),
            .stb (smp_stb),
            .cfg (cfg[c]),
            .cur (cur),
            .hit (hit[c])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            alm_q  <= 1'b0;
        end else begin
            stat_q <= (stat_q & ~{NCH{stat_rd}}) | (smp_stb ? hit : '0);
            if (smp_stb)
                alm_q <= |hit;
        end
    end

    assign alm_lvl = alm_pol ? alm_q : ~alm_q;
    assign stat_o  = stat_q;

    alm_line_mux #(.LINES(2)) u_lines (
        .rdy_en   (rdy_en),
        .rdy_line (rdy_line),
        .rdy_in   (rdy_in),
        .alm_en   (alm_en),
        .alm_line (alm_line),
        .alm_lvl  (alm_lvl),
        .gp_val   (gp_val),
        .line_o   (line_o)
    );

    // R7
    stat_set_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_stb && hit[0]) |=> stat_o[0]);

    // R7
    stat_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !smp_stb) |=> (stat_o == 2'b00));

    // R8
    alm_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !smp_stb |=> $stable(alm_q));

    // R1
    off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_stb && !src_live(c1_src) && !src_live(c2_src)) |=> !alm_q);

    // R9
    rdy_first_chk: assert property (@(posedge clk) disable iff (rst)
        rdy_en |-> (line_o[rdy_line] == rdy_in));

endmodule

// File: tb/alm_dual_monitor_test.sv
module alm_dual_monitor_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_stb = 1'b0;
    logic        use_filt = 1'b0;
    logic [11:0] raw_sup = '0, raw_aux = '0, raw_temp = '0;
    logic [13:0] raw_rate = '0;
    logic [11:0] flt_sup = '0, flt_aux = '0, flt_temp = '0;
    logic [13:0] flt_rate = '0;
    logic [2:0]  src_b [2];
    logic        roc_b [2];
    logic [7:0]  win_b [2];
    logic        gt_b  [2];
    logic [13:0] lim_b [2];
    logic        alm_en = 1'b0, alm_pol = 1'b1, alm_line = 1'b0;
    logic        rdy_en = 1'b0, rdy_line = 1'b0, rdy_in = 1'b0;
    logic [1:0]  gp_val = 2'b00;
    logic        stat_rd = 1'b0;
    logic [1:0]  stat_o, line_o;

    int n_chk = 0;
    int n_bad = 0;
    int hb [2][256];
    int hwp [2];
    int hcnt [2];
    logic [1:0] stat_e = 2'b00;
    logic       alm_e = 1'b0;

    always #5 clk = ~clk;

    alm_dual_monitor uut (
        .clk(clk), .rst(rst), .smp_stb(smp_stb), .use_filt(use_filt),
        .raw_sup(raw_sup), .raw_rate(raw_rate), .raw_aux(raw_aux), .raw_temp(raw_temp),
        .flt_sup(flt_sup), .flt_rate(flt_rate), .flt_aux(flt_aux), .flt_temp(flt_temp),
        .c1_src(src_b[0]), .c1_roc(roc_b[0]), .c1_win(win_b[0]), .c1_gt(gt_b[0]), .c1_lim(lim_b[0]),
        .c2_src(src_b[1]), .c2_roc(roc_b[1]), .c2_win(win_b[1]), .c2_gt(gt_b[1]), .c2_lim(lim_b[1]),
        .alm_en(alm_en), .alm_pol(alm_pol), .alm_line(alm_line),
        .rdy_en(rdy_en), .rdy_line(rdy_line), .rdy_in(rdy_in), .gp_val(gp_val),
        .stat_rd(stat_rd), .stat_o(stat_o), .line_o(line_o)
    );

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: run hung, actual=running expected=done");
        finish_run();
    end

    function automatic bit live_m(input logic [2:0] s);
        return s == 3'b001 || s == 3'b010 || s == 3'b101 || s == 3'b110;
    endfunction

    // R2: model of the per-source signedness
    function automatic int widen_m(input logic [2:0] s, input logic [13:0] f);
        case (s)
            3'b001, 3'b101: return int'(f[11:0]);
            3'b010:         return f[13] ? int'(f) - 16384 : int'(f);
            3'b110:         return f[11] ? int'(f[11:0]) - 4096 : int'(f[11:0]);
            default:        return 0;
        endcase
    endfunction

    function automatic logic [13:0] pick(input int c);
        case (src_b[c])
            3'b001: return {2'b00, use_filt ? flt_sup : raw_sup};
            3'b010: return use_filt ? flt_rate : raw_rate;
            3'b101: return {2'b00, use_filt ? flt_aux : raw_aux};
            3'b110: return {2'b00, use_filt ? flt_temp : raw_temp};
            default: return '0;
        endcase
    endfunction

    function automatic bit exp_hit(input int c, input int v);
        int n = (win_b[c] == 8'd0) ? 1 : int'(win_b[c]);
        int t = widen_m(src_b[c], lim_b[c]);
        int x;
        if (!live_m(src_b[c])) return 1'b0;
        if (roc_b[c]) begin
            if (hcnt[c] < n) return 1'b0;
            x = v - hb[c][(hwp[c] - n) & 255];
        end else begin
            x = v;
        end
        return gt_b[c] ? (x > t) : (x < t);
    endfunction

    function automatic logic [1:0] exp_lines();
        logic [1:0] l;
        for (int i = 0; i < 2; i++) begin
            if (rdy_en && int'(rdy_line) == i)      l[i] = rdy_in;
            else if (alm_en && int'(alm_line) == i) l[i] = alm_pol ? alm_e : ~alm_e;
            else                                    l[i] = gp_val[i];
        end
        return l;
    endfunction

    task automatic check2(input string tag, input string what, input logic [1:0] act, input logic [1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    task automatic set_cfg(input int c, input logic [2:0] s, input logic roc,
                           input logic [7:0] win, input logic gt, input logic [13:0] lim);
        if (s != src_b[c] || roc != roc_b[c]) hcnt[c] = 0;   // R5 flush
        src_b[c] = s; roc_b[c] = roc; win_b[c] = win; gt_b[c] = gt; lim_b[c] = lim;
        @(negedge clk);
    endtask

    task automatic do_sample(input string tag, input bit rd);
        int v [2];
        logic [1:0] h;
        for (int c = 0; c < 2; c++) begin
            v[c] = widen_m(src_b[c], pick(c));
            h[c] = exp_hit(c, v[c]);
        end
        smp_stb = 1'b1; stat_rd = rd;
        @(negedge clk);
        smp_stb = 1'b0; stat_rd = 1'b0;
        for (int c = 0; c < 2; c++) begin
            hb[c][hwp[c]] = v[c];
            hwp[c] = (hwp[c] + 1) & 255;
            if (hcnt[c] < 256) hcnt[c]++;
        end
        stat_e = (rd ? 2'b00 : stat_e) | h;
        alm_e  = |h;
        check2(tag, "status", stat_o, stat_e);
        check2(tag, "lines", line_o, exp_lines());
    endtask

    // R7/R8: read with no strobe
    task automatic idle_read();
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        stat_e = 2'b00;
        check2("R7", "status after read", stat_o, 2'b00);
        check2("R8", "lines held", line_o, exp_lines());
    endtask

    task automatic set_samples(input logic [11:0] s, input logic [13:0] r,
                               input logic [11:0] a, input logic [11:0] t);
        raw_sup = s; raw_rate = r; raw_aux = a; raw_temp = t;
    endtask

    initial begin
        void'($urandom(32'd4242));
        for (int c = 0; c < 2; c++) begin
            src_b[c] = 3'b000; roc_b[c] = 1'b0; win_b[c] = 8'd0; gt_b[c] = 1'b0; lim_b[c] = '0;
            hwp[c] = 0; hcnt[c] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10: reset state
        alm_en = 1'b1; alm_pol = 1'b1; alm_line = 1'b0;
        check2("R10", "status", stat_o, 2'b00);
        check2("R10", "lines", line_o, 2'b00);

        // R2: unsigned supply vs signed temperature at the same pattern
        set_cfg(0, 3'b001, 1'b0, 8'd0, 1'b1, 14'h07FF);
        set_cfg(1, 3'b110, 1'b0, 8'd0, 1'b1, 14'h07FF);
        set_samples(12'hFFF, 14'd0, 12'd0, 12'hFFF);
        do_sample("R2", 1'b0);
        idle_read();

        // R1: unused codes never trip
        set_cfg(0, 3'b011, 1'b0, 8'd0, 1'b1, 14'h3000);
        set_cfg(1, 3'b111, 1'b0, 8'd0, 1'b0, 14'h0100);
        set_samples(12'h800, 14'h1000, 12'h800, 12'h800);
        do_sample("R1", 1'b0);

        // R3: strict less, strict greater, equality
        set_cfg(0, 3'b010, 1'b0, 8'd0, 1'b0, 14'h3FFF);
        set_cfg(1, 3'b010, 1'b0, 8'd0, 1'b1, 14'd5);
        set_samples(12'd0, 14'h3FFE, 12'd0, 12'd0);
        do_sample("R3", 1'b0);
        set_samples(12'd0, 14'd5, 12'd0, 12'd0);
        do_sample("R3", 1'b1);

        // R4/R5: change mode, N=0 acts as 1, N=3 waits for history
        set_cfg(0, 3'b010, 1'b1, 8'd0, 1'b1, 14'd10);
        set_cfg(1, 3'b010, 1'b1, 8'd3, 1'b1, 14'd10);
        set_samples(12'd0, 14'd0, 12'd0, 12'd0);
        do_sample("R5", 1'b1);
        set_samples(12'd0, 14'd20, 12'd0, 12'd0);
        do_sample("R4", 1'b1);
        set_samples(12'd0, 14'd25, 12'd0, 12'd0);
        do_sample("R4", 1'b1);
        set_samples(12'd0, 14'd40, 12'd0, 12'd0);
        do_sample("R5", 1'b1);
        set_cfg(1, 3'b010, 1'b0, 8'd3, 1'b1, 14'd10);
        set_cfg(1, 3'b010, 1'b1, 8'd3, 1'b1, 14'd10);
        do_sample("R5", 1'b1);

        // R6: filtered copy differs from raw
        set_cfg(0, 3'b101, 1'b0, 8'd0, 1'b1, 14'd100);
        set_cfg(1, 3'b101, 1'b0, 8'd0, 1'b0, 14'd100);
        set_samples(12'd0, 14'd0, 12'd50, 12'd0);
        flt_aux = 12'd500; use_filt = 1'b1;
        do_sample("R6", 1'b1);
        use_filt = 1'b0;
        do_sample("R6", 1'b1);

        // R9: data-ready outranks the indicator on a shared line
        rdy_en = 1'b1; rdy_line = 1'b0; rdy_in = 1'b0; alm_line = 1'b0; gp_val = 2'b11;
        set_samples(12'd0, 14'd0, 12'd900, 12'd0);
        do_sample("R9", 1'b1);
        rdy_en = 1'b0;
        #1 check2("R9", "indicator over gp", line_o, exp_lines());
        alm_en = 1'b0;
        #1 check2("R9", "gp when idle", line_o, exp_lines());

        // R8 and all: constrained random
        for (int k = 0; k < 3000; k++) begin
            if ($urandom_range(0, 15) == 0) begin
                logic [2:0] codes [7] = '{3'b000, 3'b001, 3'b010, 3'b101, 3'b110, 3'b011, 3'b111};
                int c = $urandom_range(0, 1);
                logic [7:0] w;
                case ($urandom_range(0, 4))
                    0: w = 8'd0; 1: w = 8'd1; 2: w = 8'd2; 3: w = 8'd255;
                    default: w = 8'($urandom_range(0, 255));
                endcase
                set_cfg(c, codes[$urandom_range(0, 6)], 1'($urandom), w, 1'($urandom),
                        14'($urandom_range(0, 16383)));
            end
            if ($urandom_range(0, 7) == 0) begin
                alm_en = 1'($urandom); alm_pol = 1'($urandom); alm_line = 1'($urandom);
                rdy_en = 1'($urandom); rdy_line = 1'($urandom); rdy_in = 1'($urandom);
                gp_val = 2'($urandom);
            end
            use_filt = 1'($urandom);
            raw_sup = 12'($urandom); raw_rate = 14'($urandom);
            raw_aux = 12'($urandom); raw_temp = 12'($urandom);
            flt_sup = 12'($urandom); flt_rate = 14'($urandom);
            flt_aux = 12'($urandom); flt_temp = 12'($urandom);
            do_sample("R8", 1'($urandom_range(0, 3) == 0));
            if ($urandom_range(0, 31) == 0) idle_read();
        end

        finish_run();
    end

endmodule